// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Buffering

This block is one 16-bit timer channel. An up-counter advances on ticks from a prescaler that offers six division ratios. Four general registers (A, B, C, D) each work either as an output compare register or as an input capture register. A compare register drives one of two waveform pins when the counter reaches its value. A capture register latches the counter on a selected edge of one of two synchronized input pins.

A buffer mode pairs the registers: C backs A and D backs B. In compare mode, a match on A reloads A from C (and a match on B reloads B from D). This gives glitch-free period or duty updates. In capture mode, each new capture first pushes the previous value into the buffer, so the two most recent captures are kept.

Every register event and the counter overflow set a sticky flag. An interrupt line is raised for any flag whose enable bit is set. A plain single-cycle register bus configures the channel and reads it back.

Top module: `cc_timer_channel`

## Requirements
- R1: The 16-bit counter advances by one on each tick while the run bit (control bit 0) is 1. Control bits [3:1] select the tick period 4^sel clocks, for sel 0..5; codes 6 and 7 act as 5. The prescaler is held at zero while stopped, so the first tick falls in the first running cycle.
- R2: A register in compare mode matches when the counter equals it on a tick. Compare mode is mode bit 2 = 0 of its field at mode bits [4i+3:4i], with A=0, B=1, C=2, D=3. One cycle after a match, its pin takes the action given by field bits [1:0]. The codes are 0 none, 1 drive low, 2 drive high, 3 toggle. A and C drive pin 0; B and D drive pin 1.
- R3: No compare match, flag or pin change occurs while the run bit is 0.
- R4: A register in capture mode (field bit 2 = 1) latches the counter when its pin shows a selected edge. Field bit 0 selects the rising edge and bit 1 the falling edge. A and C sample pin 0; B and D sample pin 1. The latch happens at the third clock edge after the pin changes. Edges that are not selected have no effect.
- R5: When a capture and a bus write hit the same register in one cycle, the captured value is kept.
- R6: Control bits [6:4] name a register (1..4 for A..D; 0 for none) whose match or capture clears the counter to 0 instead of advancing it.
- R7: A tick at count 0xFFFF wraps the counter to 0 and sets the overflow flag.
- R8: Status bits 0..3 are the A..D event flags and bit 4 is the overflow flag. The flags are sticky and are cleared by writing 1 to them. irq_o is the OR of each flag ANDed with its enable bit in control bits [12:8], which use the same order.
- R9: With buffer mode on (control bit 7), a compare match on A loads C into A, and a match on B loads D into B. C and D then raise no events of their own.
- R10: With buffer mode on, a capture on A moves the old A into C and stores the count in A; B and D behave the same way.
- R11: The registers sit at address 0 control, 1 mode, 2 counter, 3 status, and 4..7 for A..D. Read data is combinational from the address. All registers and pins reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 2 | Capture input pins |
| cmp_o | output | 2 | Compare waveform pins |
| irq_o | output | 1 | Interrupt request |

## Verification
A compare match, the overflow flag and a counter clear all show one cycle after the tick that caused them. The bench gets exact ticks by writing the run bit high and then low on consecutive edges, which gives one tick per step, and reads the results at the next falling edge. A capture lands on the third rising edge after the pin changes. The capture checks therefore either hold the counter stopped and wait a few cycles, or, for the priority case, place the bus write on exactly that third edge. Prescaler runs are a known number of cycles long, and the expected count is computed as ceil(cycles / ratio).

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int BUS_W    = 16;
  localparam int NUM_GR   = 4;
  localparam int NUM_PIN  = 2;
  localparam int NUM_SRC  = 6;
  localparam int SRC_STEP = 2;
  localparam int DIV_W    = SRC_STEP * (NUM_SRC - 1);
  localparam int ADDR_W   = 3;
  localparam int FLAG_W   = NUM_GR + 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;

  typedef struct packed {
    logic [2:0]        spare;
    logic [FLAG_W-1:0] ien;
    logic              buf_en;
    logic [2:0]        clr_sel;
    logic [2:0]        clk_sel;
    logic              start;
  } ctrl_t;

  typedef enum logic [1:0] {ACT_NONE, ACT_LOW, ACT_HIGH, ACT_TOGGLE} act_e;
endpackage

// File: rtl/cc_prescaler.sv
module cc_prescaler import cc_timer_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [DIV_W:0]   span;
  logic [2:0]       sel_c;

  always_comb begin
    sel_c = (sel_i > 3'(NUM_SRC - 1)) ? 3'(NUM_SRC - 1) : sel_i;
    span  = (DIV_W+1)'(1) << (SRC_STEP * int'(sel_c));
    mask  = DIV_W'(span - 1'b1);
  end

  // held at zero while stopped so the first running cycle ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
    else             div_q <= '0;
  end

  assign tick_o = run_i && ((div_q & mask) == '0);
endmodule

// File: rtl/cc_edge_detect.sv
module cc_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0; s2_q <= 1'b0; prev_q <= 1'b0;
      end else begin
        s1_q <= pin_i[k]; s2_q <= s1_q; prev_q <= s2_q;
      end
    end
    assign rise_o[k] = s2_q & ~prev_q;
    assign fall_o[k] = ~s2_q & prev_q;
  end
endmodule

// File: rtl/cc_timer_channel.sv
module cc_timer_channel import cc_timer_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PIN-1:0]  cap_i,
  output logic [NUM_PIN-1:0]  cmp_o,
  output logic                irq_o
);
  localparam int HALF = NUM_GR / 2;

  ctrl_t                  ctrl_q;
  logic [NUM_GR-1:0][3:0] mode_q;
  logic [BUS_W-1:0]       cnt_q;
  logic [BUS_W-1:0]       gr_q [NUM_GR];
  logic [FLAG_W-1:0]      st_q, st_clr;
  logic [NUM_PIN-1:0]     cmp_q, cmp_d, rise, fall;
  logic [NUM_GR-1:0]      match, cap_evt, evt, gr_wr;
  logic                   tick, clr_hit, ovf, cnt_wr;

  cc_prescaler i_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(ctrl_q.start),
    .sel_i (ctrl_q.clk_sel), .tick_o(tick)
  );

  cc_edge_detect #(.N(NUM_PIN)) i_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(cap_i),
    .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    for (int i = 0; i < NUM_GR; i++) begin
      logic act;
      act        = !(ctrl_q.buf_en && i >= HALF);
      match[i]   = act && !mode_q[i][2] && tick && (cnt_q == gr_q[i]);
      cap_evt[i] = act && mode_q[i][2] &&
                   ((mode_q[i][0] && rise[i % NUM_PIN]) || (mode_q[i][1] && fall[i % NUM_PIN]));
      evt[i]     = match[i] | cap_evt[i];
      gr_wr[i]   = we_i && (addr_i == ADDR_W'(NUM_GR + i));
    end
    clr_hit = 1'b0;
    for (int i = 0; i < NUM_GR; i++)
      if (ctrl_q.clr_sel == 3'(i + 1) && evt[i]) clr_hit = 1'b1;
    ovf    = tick && (cnt_q == '1) && !clr_hit;
    cnt_wr = we_i && (addr_i == A_CNT);
    st_clr = (we_i && addr_i == A_STAT) ? wdata_i[FLAG_W-1:0] : '0;
  end

  always_comb begin
    cmp_d = cmp_q;
    for (int i = 0; i < NUM_GR; i++) begin
      if (match[i]) begin
        case (act_e'(mode_q[i][1:0]))
          ACT_LOW:    cmp_d[i % NUM_PIN] = 1'b0;
          ACT_HIGH:   cmp_d[i % NUM_PIN] = 1'b1;
          ACT_TOGGLE: cmp_d[i % NUM_PIN] = ~cmp_d[i % NUM_PIN];
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      cnt_q  <= '0;
      st_q   <= '0;
      cmp_q  <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i);
      if (we_i && addr_i == A_MODE) mode_q <= wdata_i;
      if (cnt_wr)       cnt_q <= wdata_i;
      else if (clr_hit) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;
      // set wins over a same-cycle clear
      st_q  <= (st_q & ~st_clr) | {ovf, evt};
      cmp_q <= cmp_d;
    end
  end

  for (genvar p = 0; p < HALF; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            gr_q[p] <= '0;
      else if (cap_evt[p])                    gr_q[p] <= cnt_q;
      else if (ctrl_q.buf_en && match[p])     gr_q[p] <= gr_q[p+HALF];
      else if (gr_wr[p])                      gr_q[p] <= wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            gr_q[p+HALF] <= '0;
      else if (ctrl_q.buf_en && cap_evt[p])   gr_q[p+HALF] <= gr_q[p];
      else if (cap_evt[p+HALF])               gr_q[p+HALF] <= cnt_q;
      else if (gr_wr[p+HALF])                 gr_q[p+HALF] <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_MODE:  rdata_o = mode_q;
      A_CNT:   rdata_o = cnt_q;
      A_STAT:  rdata_o = BUS_W'(st_q);
      default: rdata_o = gr_q[addr_i[1:0]];
    endcase
  end

  assign cmp_o = cmp_q;
  assign irq_o = |(st_q & ctrl_q.ien);

  assert_hold_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.start |=> $stable(cmp_o));
  assert_wrap_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[FLAG_W-1]) |-> $past(cnt_q) == '1);
  assert_clear_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !cnt_wr) |=> cnt_q == '0);
  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag_chk
    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[k] && !st_clr[k]) |=> st_q[k]);
  end
  for (genvar k = 0; k < HALF; k++) begin : g_cap_chk
    assert_capture_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt[k] |=> gr_q[k] == $past(cnt_q));
  end
endmodule

// File: tb/test_cc_timer_channel.sv
`timescale 1ns/1ps
module test_cc_timer_channel;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0]  cap = '0, cmp;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cc_timer_channel i_cc_timer_channel (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
  );

  // callers sit at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    addr = a; #1;
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] base);
    wr(3'd0, base | 16'h1);
    wr(3'd0, base);
  endtask

  task automatic run(input logic [15:0] base, input int n);
    wr(3'd0, base | 16'h1);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, base);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 ctrl reset", 3'd0, 16'h0);
    chk("R11 count reset", 3'd2, 16'h0);
    chk("R11 status reset", 3'd3, 16'h0);
    chk_bit("R11 cmp reset", cmp[0] | cmp[1], 1'b0);
    chk_bit("R11 irq reset", irq, 1'b0);
  endtask

  task automatic t_prescale;
    wr(3'd1, 16'h4444);
    wr(3'd2, 16'h0); run(16'h0000, 5);  chk("R1 div1 5 cycles", 3'd2, 16'd5);
    wr(3'd2, 16'h0); run(16'h0002, 10); chk("R1 div4 10 cycles", 3'd2, 16'd3);
    wr(3'd2, 16'h0); run(16'h0004, 40); chk("R1 div16 40 cycles", 3'd2, 16'd3);
  endtask

  task automatic t_compare;
    wr(3'd3, 16'h1F);
    wr(3'd1, 16'h4432);
    wr(3'd4, 16'd10); wr(3'd5, 16'd10);
    wr(3'd2, 16'd10); step(16'h0);
    chk_bit("R2 pin0 high", cmp[0], 1'b1); chk_bit("R2 pin1 toggle", cmp[1], 1'b1);
    chk("R2 flags A B", 3'd3, 16'h0003);
    chk("R1 step count", 3'd2, 16'd11);
    wr(3'd2, 16'd10); step(16'h0);
    chk_bit("R2 pin0 hold", cmp[0], 1'b1); chk_bit("R2 pin1 toggle back", cmp[1], 1'b0);
    wr(3'd1, 16'h4431);
    wr(3'd2, 16'd10); step(16'h0);
    chk_bit("R2 pin0 low", cmp[0], 1'b0); chk_bit("R2 pin1 toggle again", cmp[1], 1'b1);
  endtask

  task automatic t_stopped;
    wr(3'd1, 16'h4433);
    wr(3'd3, 16'h1F);
    wr(3'd2, 16'd10);
    wait_n(6);
    chk("R3 no flag stopped", 3'd3, 16'h0);
    chk_bit("R3 pin0 stays", cmp[0], 1'b0); chk_bit("R3 pin1 stays", cmp[1], 1'b1);
  endtask

  task automatic t_overflow;
    wr(3'd1, 16'h4444);
    wr(3'd3, 16'h1F);
    wr(3'd2, 16'hFFFF); step(16'h1000);
    chk("R7 wrap", 3'd2, 16'h0);
    chk("R7 ovf flag", 3'd3, 16'h0010);
    chk_bit("R8 irq on", irq, 1'b1);
    wr(3'd3, 16'h0010);
    chk("R8 w1c", 3'd3, 16'h0);
    chk_bit("R8 irq off", irq, 1'b0);
  endtask

  task automatic t_clear_match;
    wr(3'd1, 16'h4440);
    wr(3'd4, 16'd7);
    wr(3'd2, 16'd7); step(16'h0010);
    chk("R6 cleared on match", 3'd2, 16'h0);
    chk("R6 flag A", 3'd3, 16'h0001);
    chk_bit("R8 irq masked", irq, 1'b0);
  endtask

  task automatic t_buf_compare;
    wr(3'd3, 16'h1F);
    wr(3'd1, 16'h4440);
    wr(3'd4, 16'd3); wr(3'd6, 16'd9);
    wr(3'd2, 16'd3); step(16'h0080);
    chk("R9 A reloaded from C", 3'd4, 16'd9);
    chk("R9 count advanced", 3'd2, 16'd4);
    wr(3'd2, 16'd9); step(16'h0080);
    chk("R9 C raises no flag", 3'd3, 16'h0001);
  endtask

  task automatic t_capture;
    wr(3'd0, 16'h0020);
    wr(3'd1, 16'h4464);
    wr(3'd5, 16'h0); wr(3'd2, 16'h0100);
    cap[1] = 1'b1; wait_n(5);
    chk("R4 rising ignored", 3'd5, 16'h0);
    chk("R6 no clear without capture", 3'd2, 16'h0100);
    cap[1] = 1'b0; wait_n(5);
    chk("R4 falling captured", 3'd5, 16'h0100);
    chk("R6 cleared on capture", 3'd2, 16'h0);
    wr(3'd0, 16'h0);
    wr(3'd1, 16'h4447);
    wr(3'd2, 16'h0055); cap[0] = 1'b1; wait_n(5);
    chk("R4 both rise", 3'd4, 16'h0055);
    wr(3'd2, 16'h0066); cap[0] = 1'b0; wait_n(5);
    chk("R4 both fall", 3'd4, 16'h0066);
  endtask

  task automatic t_buf_capture;
    wr(3'd1, 16'h4445);
    wr(3'd4, 16'h1111); wr(3'd6, 16'h0); wr(3'd2, 16'h2222);
    wr(3'd0, 16'h0080);
    cap[0] = 1'b1; wait_n(5);
    chk("R10 new in A", 3'd4, 16'h2222);
    chk("R10 old in C", 3'd6, 16'h1111);
    cap[0] = 1'b0; wait_n(5);
    wr(3'd0, 16'h0);
  endtask

  task automatic t_priority;
    wr(3'd1, 16'h4445);
    wr(3'd4, 16'h0); wr(3'd2, 16'h0ABC);
    cap[0] = 1'b1;
    wait_n(2);
    wr(3'd4, 16'hDEAD);
    chk("R5 capture beats write", 3'd4, 16'h0ABC);
    wr(3'd4, 16'h1234);
    chk("R11 plain write", 3'd4, 16'h1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_compare();
    t_stopped();
    t_overflow();
    t_clear_match();
    t_buf_compare();
    t_capture();
    t_buf_capture();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule